// File: doc/BRIEF.md
# Serial Flash Full-Array Erase Controller

This block is the command side of a small serial flash device. It listens as a target on a mode-0 SPI bus, which it samples with its own system clock. It takes one opcode per chip-select frame. Three opcodes change the device: one sets the write-enable latch, one clears it, and one erases the whole array. A fourth opcode returns a status byte, and the status byte repeats for as long as the host keeps clocking. A strapped two-bit protect field blocks the erase. When an erase runs, a self-timed counter holds the busy flag high. The latch drops at the halfway count. When the count ends, every byte of the storage model becomes 0xFF in a single cycle.

The controller is a state machine with seven states.
- **IDLE**: chip select is high.
- **CMD**: the first byte is being shifted in.
- **ARM_SET**, **ARM_CLR** and **ARM_ERASE**: a complete opcode has arrived and waits for chip select to rise.
- **STATUS**: the status byte is streaming out.
- **DISCARD**: the rest of the frame is ignored.

The transitions are as follows.
- IDLE→CMD on a falling chip select.
- CMD→ARM_* or STATUS when the eighth bit decodes to a known opcode that is allowed.
- CMD→DISCARD for an unknown opcode, or for any opcode other than status while busy.
- ARM_*→DISCARD when a ninth clock edge arrives.
- Any state→IDLE on a rising chip select. A command takes effect only on the ARM_*→IDLE transition.

Top module: `fce_bulk_erase`

## Requirements
- R1: After reset, `busy` and `wr_latch` are 0, `spi_miso` is 0, and array byte i holds {1'b0, i[6:0]}.
- R2: Opcodes are shifted in MSB first on rising SCLK. 0x06 sets the write-enable latch and 0x04 clears it. The change appears on the third system-clock edge after the rising chip select is sampled.
- R3: Opcode 0x05 streams the status byte on MISO, MSB first, with each bit updated after a falling SCLK. The layout is bit0 busy, bit1 latch, bits3:2 = `prot_bits`, bits7:4 zero. The byte is captured again from live state at the start of every byte.
- R4: Opcode 0xC7 starts an erase only if all three hold: the latch is 1, `prot_bits` is 2'b00, and chip select rises after exactly 8 bits. Otherwise nothing changes.
- R5: `busy` rises on the third system-clock edge after chip select rises and stays high for exactly ERASE_CYCLES clocks.
- R6: The latch clears ERASE_CYCLES/2 clocks after `busy` rose, while `busy` is still 1.
- R7: Array contents are unchanged during the erase. All bytes read 0xFF from the cycle in which `busy` falls.
- R8: While `busy` is 1, every opcode except 0x05 is ignored.
- R9: A chip-select rise after any bit count other than 8, or an unknown opcode, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sclk | input | 1 | SPI serial clock, mode 0 |
| spi_mosi | input | 1 | SPI data into the device |
| spi_miso | output | 1 | SPI data out of the device (status stream) |
| prot_bits | input | 2 | Strapped block-protect field |
| busy | output | 1 | Erase in progress |
| wr_latch | output | 1 | Write-enable latch |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at `rd_addr` |

## Verification
The bench builds the block with ERASE_CYCLES=600 and ARRAY_BYTES=32. With these values a whole erase cycle spans only a few SPI bytes. This puts the latch midpoint between two status bytes polled in one frame, and it lets a disable opcode land before the midpoint, where ignoring it is visible. The small array lets every byte be read back after the erase.

// File: rtl/fce_pkg.sv
package fce_pkg;

    localparam logic [7:0] OP_LATCH_SET  = 8'h06;
    localparam logic [7:0] OP_LATCH_CLR  = 8'h04;
    localparam logic [7:0] OP_STAT_READ  = 8'h05;
    localparam logic [7:0] OP_FULL_ERASE = 8'hC7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ARM_SET,
        ST_ARM_CLR,
        ST_ARM_ERASE,
        ST_STATUS,
        ST_DISCARD
    } ctl_state_t;

    typedef struct packed {
        logic [3:0] zero;
        logic [1:0] prot;
        logic       latch;
        logic       busy;
    } status_t;

    // Pick the state that follows a complete first byte.
    function automatic ctl_state_t decode_op(input logic [7:0] op, input logic busy);
        ctl_state_t nxt;
        nxt = ST_DISCARD;
        if (busy) begin
            if (op == OP_STAT_READ) nxt = ST_STATUS;
        end else begin
            case (op)
                OP_LATCH_SET:  nxt = ST_ARM_SET;
                OP_LATCH_CLR:  nxt = ST_ARM_CLR;
                OP_STAT_READ:  nxt = ST_STATUS;
                OP_FULL_ERASE: nxt = ST_ARM_ERASE;
                default:       nxt = ST_DISCARD;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/fce_spi_rx.sv
module fce_spi_rx #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_i,
    input  logic             sclk_i,
    input  logic             mosi_i,
    output logic             cs_fall_o,
    output logic             cs_rise_o,
    output logic             sclk_rise_o,
    output logic             sclk_fall_o,
    output logic             byte_done_o,
    output logic [7:0]       byte_o,
    output logic [CNT_W-1:0] bit_cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(7);

    // Synchronizer chains; SYNC_STAGES is expected to be at least 2.
    logic [SYNC_STAGES-1:0] cs_sync, sclk_sync, mosi_sync;
    logic                   cs_prev, sclk_prev;
    logic                   cs_now, sclk_now, mosi_now;
    logic [6:0]             shift_q;
    logic [CNT_W-1:0]       cnt_q;

    assign cs_now   = cs_sync[SYNC_STAGES-1];
    assign sclk_now = sclk_sync[SYNC_STAGES-1];
    assign mosi_now = mosi_sync[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_sync   <= '1;
            sclk_sync <= '0;
            mosi_sync <= '0;
            cs_prev   <= 1'b1;
            sclk_prev <= 1'b0;
        end else begin
            cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_n_i};
            sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk_i};
            mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi_i};
            cs_prev   <= cs_now;
            sclk_prev <= sclk_now;
        end
    end

    assign cs_fall_o   = cs_prev & ~cs_now;
    assign cs_rise_o   = ~cs_prev & cs_now;
    assign sclk_rise_o = ~sclk_prev & sclk_now & ~cs_now;
    assign sclk_fall_o = sclk_prev & ~sclk_now & ~cs_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shift_q <= '0;
        end else begin
            if (cs_now) begin
                cnt_q <= '0;
            end else if (sclk_rise_o && cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (sclk_rise_o) begin
                shift_q <= {shift_q[5:0], mosi_now};
            end
        end
    end

    assign byte_done_o = sclk_rise_o && (cnt_q == CNT_LAST);
    assign byte_o      = {shift_q, mosi_now};
    assign bit_cnt_o   = cnt_q;

    // R9
    frame_count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise_o |=> (bit_cnt_o == '0));

endmodule

// File: rtl/fce_status_tx.sv
module fce_status_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       shift_i,
    input  logic [7:0] status_i,
    output logic       miso_o
);

    logic [2:0] idx_q;
    logic [7:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            sh_q   <= '0;
            miso_o <= 1'b0;
        end else if (!en_i) begin
            idx_q  <= '0;
            sh_q   <= '0;
            miso_o <= 1'b0;
        end else if (shift_i) begin
            if (idx_q == 3'd0) begin
                miso_o <= status_i[7];
                sh_q   <= {status_i[6:0], 1'b0};
            end else begin
                miso_o <= sh_q[7];
                sh_q   <= {sh_q[6:0], 1'b0};
            end
            idx_q <= idx_q + 3'd1;
        end
    end

    // R3
    status_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !$past(en_i)) |-> !miso_o);

endmodule

// File: rtl/fce_erase_timer.sv
module fce_erase_timer #(
    parameter int CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic mid_o,
    output logic done_o
);

    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam int MID   = CYCLES - CYCLES / 2;

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start_i && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(CYCLES - 1);
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign busy_o = busy_q;
    assign mid_o  = busy_q && (cnt_q == CNT_W'(MID));
    assign done_o = busy_q && (cnt_q == '0);

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !done_o) |=> busy_q);

endmodule

// File: rtl/fce_mem_model.sv
module fce_mem_model #(
    parameter int BYTES  = 256,
    parameter int ADDR_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o
);

    logic [7:0] mem_q [BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) mem_q[i] <= {1'b0, 7'(i)};
        end else if (clr_i) begin
            for (int i = 0; i < BYTES; i++) mem_q[i] <= 8'hFF;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

    // R7
    erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (mem_q[0] == 8'hFF && mem_q[BYTES-1] == 8'hFF));

endmodule

// File: rtl/fce_bulk_erase.sv
module fce_bulk_erase
    import fce_pkg::*;
#(
    parameter int ERASE_CYCLES = 4096,
    parameter int ARRAY_BYTES  = 256,
    parameter int ADDR_W       = $clog2(ARRAY_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [1:0]        prot_bits,
    output logic              busy,
    output logic              wr_latch,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam int CNT_W = 4;
    localparam logic [CNT_W-1:0] FULL_BYTE = CNT_W'(8);

    logic             cs_fall, cs_rise, sclk_rise, sclk_fall, byte_done;
    logic [7:0]       byte_v;
    logic [CNT_W-1:0] bit_cnt;
    logic             mid_pulse, done_pulse;
    logic             start_erase, set_latch, clr_latch, stat_en;
    logic             latch_q;
    logic             at_boundary;
    status_t          status;
    ctl_state_t       state_q, state_d;

    fce_spi_rx #(.SYNC_STAGES(2), .CNT_W(CNT_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n_i      (spi_cs_n),
        .sclk_i      (spi_sclk),
        .mosi_i      (spi_mosi),
        .cs_fall_o   (cs_fall),
        .cs_rise_o   (cs_rise),
        .sclk_rise_o (sclk_rise),
        .sclk_fall_o (sclk_fall),
        .byte_done_o (byte_done),
        .byte_o      (byte_v),
        .bit_cnt_o   (bit_cnt)
    );

    fce_erase_timer #(.CYCLES(ERASE_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_erase),
        .busy_o  (busy),
        .mid_o   (mid_pulse),
        .done_o  (done_pulse)
    );

    fce_mem_model #(.BYTES(ARRAY_BYTES), .ADDR_W(ADDR_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (done_pulse),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

    assign status = '{zero: 4'b0000, prot: prot_bits, latch: latch_q, busy: busy};

    fce_status_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (stat_en),
        .shift_i  (sclk_fall),
        .status_i (status),
        .miso_o   (spi_miso)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cs_fall) state_d = ST_CMD;
            end
            ST_CMD: begin
                if (cs_rise)        state_d = ST_IDLE;
                else if (byte_done) state_d = decode_op(byte_v, busy);
            end
            ST_ARM_SET, ST_ARM_CLR, ST_ARM_ERASE: begin
                if (cs_rise)        state_d = ST_IDLE;
                else if (sclk_rise) state_d = ST_DISCARD;
            end
            ST_STATUS, ST_DISCARD: begin
                if (cs_rise) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs of the state machine
    assign at_boundary = (bit_cnt == FULL_BYTE);

    always_comb begin
        start_erase = 1'b0;
        set_latch   = 1'b0;
        clr_latch   = 1'b0;
        stat_en     = 1'b0;
        unique case (state_q)
            ST_ARM_SET:   set_latch   = cs_rise && at_boundary;
            ST_ARM_CLR:   clr_latch   = cs_rise && at_boundary;
            ST_ARM_ERASE: start_erase = cs_rise && at_boundary && latch_q
                                        && (prot_bits == 2'b00) && !busy;
            ST_STATUS:    stat_en     = 1'b1;
            default: ;
        endcase
    end

    // Write-enable latch: the erase midpoint outranks commands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         latch_q <= 1'b0;
        else if (mid_pulse) latch_q <= 1'b0;
        else if (set_latch) latch_q <= 1'b1;
        else if (clr_latch) latch_q <= 1'b0;
    end

    assign wr_latch = latch_q;

    // R4
    erase_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(latch_q) && $past(prot_bits) == 2'b00));

    // R5
    erase_from_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(state_q) == ST_ARM_ERASE));

    // R6
    latch_gone_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !latch_q);

    // R8
    busy_blocks_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_q) |-> !$past(busy));

    // R9
    arm_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM_SET || state_q == ST_ARM_CLR || state_q == ST_ARM_ERASE)
            |-> at_boundary);

endmodule

// File: tb/fce_bulk_erase_test.sv
module fce_bulk_erase_test;

    localparam int N    = 600;
    localparam int NB   = 32;
    localparam int AW   = $clog2(NB);
    localparam int HALF = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          sclk = 1'b0;
    logic          mosi = 1'b0;
    logic [1:0]    prot = 2'b00;
    logic [AW-1:0] rd_addr = '0;
    logic          miso, busy, wel;
    logic [7:0]    rd_data;

    fce_bulk_erase #(.ERASE_CYCLES(N), .ARRAY_BYTES(NB)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_cs_n  (cs_n),
        .spi_sclk  (sclk),
        .spi_mosi  (mosi),
        .spi_miso  (miso),
        .prot_bits (prot),
        .busy      (busy),
        .wr_latch  (wel),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    // Reference model state
    bit exp_wip = 1'b0;
    bit exp_wel = 1'b0;
    bit erasing = 1'b0;
    int e_start = 0;
    int pend_cyc = -1;
    int pend_act = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Per-clock comparison against the model (R2/R5/R6/R8)
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend_cyc == cyc) begin
                case (pend_act)
                    1: exp_wel = 1'b1;
                    2: exp_wel = 1'b0;
                    3: begin exp_wip = 1'b1; erasing = 1'b1; e_start = cyc; end
                    default: ;
                endcase
                pend_cyc = -1;
            end
            if (erasing) begin
                if (cyc == e_start + N / 2) exp_wel = 1'b0;
                if (cyc == e_start + N) begin exp_wip = 1'b0; erasing = 1'b0; end
            end
            chk("R5 busy per clock", busy, exp_wip);
            chk("R6 latch per clock", wel, exp_wel);
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < nbits; i++) begin
            mosi = tx[7 - (i % 8)];
            tick(HALF);
            rx = {rx[6:0], miso};
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
        end
    endtask

    // One command frame; the model decides its effect at the chip-select rise.
    task automatic send(input logic [7:0] op, input int nbits);
        logic [7:0] dummy;
        int act;
        cs_n = 1'b0;
        tick(HALF);
        xfer(op, nbits, dummy);
        tick(HALF);
        act = 0;
        if (nbits == 8 && !exp_wip) begin
            case (op)
                8'h06: act = 1;
                8'h04: act = 2;
                8'hC7: if (exp_wel && prot == 2'b00) act = 3;
                default: act = 0;
            endcase
        end
        cs_n = 1'b1;
        if (act != 0) begin pend_act = act; pend_cyc = cyc + 3; end
        tick(4 * HALF);
    endtask

    task automatic rd_stat(output logic [7:0] s1, output logic [7:0] s2);
        logic [7:0] dummy;
        cs_n = 1'b0;
        tick(HALF);
        xfer(8'h05, 8, dummy);
        xfer(8'h00, 8, s1);
        xfer(8'h00, 8, s2);
        tick(HALF);
        cs_n = 1'b1;
        tick(4 * HALF);
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] s1, s2;
        tick(5);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 latch", wel, 0);
        chk("R1 miso", miso, 0);
        rd_addr = AW'(5);  #1; chk("R1 array[5]", rd_data, 8'h05);
        rd_addr = AW'(31); #1; chk("R1 array[31]", rd_data, 8'h1F);

        // R3 idle status
        rd_stat(s1, s2);
        chk("R3 idle status", s1, 8'h00);

        // R4 erase without the latch is ignored
        send(8'hC7, 8);
        tick(10);
        chk("R4 no erase without latch", busy, 0);

        // R9 set-latch opcode with 7 bits has no effect
        send(8'h06, 7);
        chk("R9 short frame", wel, 0);

        // R2 set then clear
        send(8'h06, 8);
        chk("R2 latch set", wel, 1);
        rd_stat(s1, s2);
        chk("R3 status latch", s1, 8'h02);
        chk("R3 status repeat", s2, 8'h02);
        send(8'h04, 8);
        chk("R2 latch clear", wel, 0);
        send(8'h06, 8);

        // R9 unknown opcode and wrong lengths
        send(8'hAB, 8);
        chk("R9 unknown opcode", wel, 1);
        send(8'hC7, 7);
        chk("R9 erase 7 bits", busy, 0);
        send(8'hC7, 9);
        chk("R9 erase 9 bits", busy, 0);

        // R4 protection blocks the erase
        prot = 2'b01;
        send(8'hC7, 8);
        chk("R4 prot01 blocks", busy, 0);
        rd_stat(s1, s2);
        chk("R3 status prot01", s1, 8'h06);
        prot = 2'b10;
        send(8'hC7, 8);
        chk("R4 prot10 blocks", busy, 0);
        rd_stat(s1, s2);
        chk("R3 status prot10", s1, 8'h0A);
        prot = 2'b00;
        rd_addr = AW'(7); #1;
        chk("R7 untouched after blocked", rd_data, 8'h07);

        // R4/R5 valid erase
        send(8'hC7, 8);
        chk("R5 busy after start", busy, 1);
        chk("R7 unchanged during erase", rd_data, 8'h07);
        // R8 clear-latch opcode while busy is ignored (latch stays until midpoint)
        send(8'h04, 8);
        chk("R8 clear ignored while busy", wel, 1);
        // R6 polling straddles the midpoint
        rd_stat(s1, s2);
        chk("R6 status before mid", s1, 8'h03);
        chk("R6 status after mid", s2, 8'h01);
        chk("R7 unchanged late in erase", rd_data, 8'h07);

        for (int w = 0; w < 2000 && busy; w++) tick(1);
        tick(2);
        chk("R5 busy ended", busy, 0);
        rd_stat(s1, s2);
        chk("R3 status after erase", s1, 8'h00);
        for (int a = 0; a < NB; a++) begin
            rd_addr = AW'(a);
            #1;
            chk("R7 byte erased", rd_data, 8'hFF);
        end

        // R8/R4 a second erase needs a new latch set
        send(8'hC7, 8);
        tick(5);
        chk("R4 no repeat without latch", busy, 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule